// File: doc/BRIEF.md
# Programmable Third-Order Comb-Integrator Decimator

This block turns the single-bit stream of a second-order sigma-delta modulator into signed 16-bit PCM words. Each modulator bit arrives with a clock-enable strobe and counts as +1 when high and -1 when low. The stream passes through three cascaded integrators, is sampled once every M enabled inputs, and then runs through three comb differencers. Together these give the response ((1 - z^-M)/(1 - z^-1))^3. The decimation factor M is picked by a two-bit rate code and can be any power of two from 32 to 256. With a 2.048 MHz modulator this gives output rates from 64 ksps down to 8 ksps.

The gain of the filter is M^3, so the output is shifted right by an amount taken from M. A full-scale input therefore lands on the 16-bit range, and the one positive overflow code is clipped. The integrators are sized for the largest M and wrap modulo their width. When the rate code changes, the comb delay registers are cleared and the decimation phase restarts. A small controller with two states holds the output strobe back until the comb pipeline again holds valid history.

The controller states are:
- ST_PRIME: decimation points are counted and discarded.
- ST_RUN: every decimation point produces a sample.

The transitions are:
- Reset enters ST_PRIME.
- Any change of the rate code enters ST_PRIME from either state.
- The third discarded decimation point moves ST_PRIME to ST_RUN.
- ST_RUN stays in ST_RUN while the rate code is unchanged.

Top module: `sinc3_decim`

## Requirements
- R1: Input bit 1 counts as +1 and bit 0 as -1. A steady all-ones stream settles to 32767 (clipped from +32768), and a steady all-zeros stream settles to -32768, at every rate.
- R2: Rate code s (0 to 3) on `rate_sel` selects M = 32 * 2^s enabled inputs per output sample.
- R3: `pcm_valid` is a single-cycle pulse. It rises one clock after the Mth enabled input of a window, and windows follow each other with exactly M enabled inputs each.
- R4: A cycle with `mod_en` low does not change the filter state or the phase, the value of `mod_bit` in that cycle has no effect, and no `pcm_valid` follows such a cycle.
- R5: After reset, or after a cycle in which `rate_sel` differs from the rate in force, the first three decimation points are discarded. The first `pcm_valid` then comes after 4*M enabled inputs, and none comes in the cycle right after the change.
- R6: The output is the filter sum arithmetically shifted right by 3*log2(M) - 15 and clipped to 16 bits. A periodic stream with mean density d settles to d*32768 (for example, a density of +0.5 gives 16384 and a density of -0.75 gives -24576).
- R7: A stream with equal numbers of ones and zeros and a period that divides M settles to exactly 0.
- R8: Reset clears `pcm_out` and `pcm_valid` to zero, and `pcm_out` holds its value in every cycle without `pcm_valid`.
- R9: Integrator wraparound never corrupts the output. Long runs at M = 256 keep yielding exact settled values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Qualifies `mod_bit` for this cycle |
| mod_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| rate_sel | input | SEL_W | Rate code, M = 32 * 2^rate_sel |
| pcm_out | output | OUT_W | Signed decimated sample |
| pcm_valid | output | 1 | One-cycle strobe marking a new `pcm_out` |

## Verification
A wrong phase count or a stuck controller state shows up at the ports as a `pcm_valid` spacing other than M. It can also show up as a missing or early first strobe after a rate change, visible at the very next strobe, within 4*M enabled inputs. A corrupted integrator or comb register, or a wrong shift amount, leaves the settled PCM value off its arithmetic mean-density target. Because the periodic test streams make every settled output a known constant, this appears within five decimation periods of the fault. Enable gaps filled with inverted bits reveal any leak of a disabled cycle into the sums at the next settled sample.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    localparam int ORDER = 3;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } dec_state_t;
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] acc_out
);
    import sinc3_pkg::*;

    logic [W-1:0] step;
    assign step = bit_in ? W'(1) : {W{1'b1}};

    for (genvar g = 0; g < ORDER; g++) begin : stg
        logic [W-1:0] r;
        logic [W-1:0] feed;
        if (g == 0) begin : g_first
            assign feed = step;
        end else begin : g_next
            assign feed = stg[g-1].r;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (en) begin
                r <= r + feed;
            end
        end
    end

    assign acc_out = stg[ORDER-1].r;
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    import sinc3_pkg::*;

    for (genvar g = 0; g < ORDER; g++) begin : stg
        logic [W-1:0] src;
        logic [W-1:0] dly;
        logic [W-1:0] dif;
        if (g == 0) begin : g_first
            assign src = din;
        end else begin : g_next
            assign src = stg[g-1].dif;
        end
        assign dif = src - dly;
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                dly <= '0;
            end else if (tick) begin
                dly <= src;
            end
        end
    end

    assign dout = stg[ORDER-1].dif;
endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
    parameter int SEL_W   = 2,
    parameter int LOG_MIN = 5,
    parameter int PH_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick,
    output logic             clr,
    output logic             emit,
    output logic [SEL_W-1:0] cur_sel
);
    import sinc3_pkg::*;

    localparam int DROP_N = ORDER;

    dec_state_t       state;
    logic [PH_W-1:0]  phase;
    logic [1:0]       drop_cnt;
    logic [PH_W:0]    m_val;
    logic             changed;
    logic             last;
    logic             in_run;

    assign m_val   = (PH_W+1)'(1) << (LOG_MIN + int'(cur_sel));
    assign changed = (rate_sel != cur_sel);
    assign last    = ({1'b0, phase} == (m_val - 1'b1));

    // state register, phase and discard counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_PRIME;
            cur_sel  <= '0;
            phase    <= '0;
            drop_cnt <= '0;
        end else if (changed) begin
            state    <= ST_PRIME;
            cur_sel  <= rate_sel;
            phase    <= '0;
            drop_cnt <= '0;
        end else if (mod_en) begin
            phase <= last ? '0 : phase + 1'b1;
            if (last) begin
                unique case (state)
                    ST_PRIME: begin
                        if (drop_cnt == 2'(DROP_N - 1)) begin
                            state <= ST_RUN;
                        end else begin
                            drop_cnt <= drop_cnt + 1'b1;
                        end
                    end
                    ST_RUN: state <= ST_RUN;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PRIME: in_run = 1'b0;
            ST_RUN:   in_run = 1'b1;
        endcase
        clr  = changed;
        tick = mod_en && last && !changed;
        emit = tick && in_run;
    end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
    parameter int SEL_W   = 2,
    parameter int LOG_MIN = 5,
    parameter int OUT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             mod_bit,
    input  logic [SEL_W-1:0] rate_sel,
    output logic [OUT_W-1:0] pcm_out,
    output logic             pcm_valid
);
    import sinc3_pkg::*;

    localparam int LOG_MAX = LOG_MIN + (1 << SEL_W) - 1;
    localparam int ACC_W   = ORDER * LOG_MAX + 2;
    localparam int PH_W    = LOG_MAX;
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (OUT_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - 1;

    logic [ACC_W-1:0]         integ_q;
    logic [ACC_W-1:0]         comb_q;
    logic                     tick;
    logic                     clr;
    logic                     emit;
    logic [SEL_W-1:0]         cur_sel;
    logic [5:0]               sh;
    logic signed [ACC_W-1:0]  shifted;
    logic [OUT_W-1:0]         clipped;

    sinc3_integ #(.W(ACC_W)) integ_i (
        .clk(clk), .rst_n(rst_n), .en(mod_en), .bit_in(mod_bit), .acc_out(integ_q)
    );

    sinc3_ctrl #(.SEL_W(SEL_W), .LOG_MIN(LOG_MIN), .PH_W(PH_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .rate_sel(rate_sel),
        .tick(tick), .clr(clr), .emit(emit), .cur_sel(cur_sel)
    );

    sinc3_comb #(.W(ACC_W)) comb_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .din(integ_q), .dout(comb_q)
    );

    assign sh      = 6'(ORDER * (LOG_MIN + int'(cur_sel)) - (OUT_W - 1));
    assign shifted = $signed(comb_q) >>> sh;

    always_comb begin
        if (shifted > POS_LIM) begin
            clipped = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (shifted < NEG_LIM) begin
            clipped = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            clipped = shifted[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcm_out   <= '0;
            pcm_valid <= 1'b0;
        end else begin
            pcm_valid <= emit;
            if (emit) begin
                pcm_out <= clipped;
            end
        end
    end
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
    parameter int SEL_W   = 2,
    parameter int LOG_MIN = 5,
    parameter int OUT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_en,
    input logic [SEL_W-1:0] rate_sel,
    input logic [OUT_W-1:0] pcm_out,
    input logic             pcm_valid
);
    localparam int LOG_MAX = LOG_MIN + (1 << SEL_W) - 1;
    localparam int WIN_W   = LOG_MAX + 4;

    logic [SEL_W-1:0] prev_sel;
    logic [WIN_W-1:0] win;
    logic             first;
    logic [WIN_W-1:0] win_exp;
    logic             sel_moved;

    assign sel_moved = (rate_sel != prev_sel);
    assign win_exp   = WIN_W'((first ? 4 : 1) << (LOG_MIN + int'(prev_sel)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel <= '0;
            win      <= '0;
            first    <= 1'b1;
        end else begin
            prev_sel <= rate_sel;
            if (sel_moved) begin
                win   <= '0;
                first <= 1'b1;
            end else if (pcm_valid) begin
                win   <= WIN_W'(mod_en);
                first <= 1'b0;
            end else if (mod_en) begin
                win <= win + 1'b1;
            end
        end
    end

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid);

    // R3 spacing and R5 start-up window, counted in enabled inputs
    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_valid && !sel_moved) |-> (win == win_exp));

    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> !pcm_valid);

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_moved |=> !pcm_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_valid |-> $stable(pcm_out));
endmodule

bind sinc3_decim sinc3_decim_chk #(.SEL_W(SEL_W), .LOG_MIN(LOG_MIN), .OUT_W(OUT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .rate_sel(rate_sel),
    .pcm_out(pcm_out), .pcm_valid(pcm_valid)
);

// File: tb/sinc3_decim_tb_top.sv
module sinc3_decim_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mod_en;
    logic        mod_bit;
    logic [1:0]  rate_sel;
    logic [15:0] pcm_out;
    logic        pcm_valid;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int n_in = 0;
    int vcount = 0;
    int cur_m = 32;
    int exp_val = 0;
    bit first_flag = 1'b1;
    string vtag = "R1";

    int          per_a [7] = '{1, 1, 2, 4, 4, 8, 8};
    logic [7:0]  mask_a[7] = '{8'h01, 8'h00, 8'h01, 8'h07, 8'h01, 8'h7F, 8'h01};

    always #10 clk = ~clk;

    sinc3_decim dut_i (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
        .rate_sel(rate_sel), .pcm_out(pcm_out), .pcm_valid(pcm_valid)
    );

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog: run hung, actual %0d cycles, expected under 150000", cyc);
                report();
                $finish;
            end
        end
    end

    // sample at negedge, then drive the next inputs
    task automatic io(input logic b, input logic e);
        int want;
        @(negedge clk);
        if (pcm_valid) begin
            vcount++;
            tests++;
            want = first_flag ? 4 * cur_m : cur_m;
            if (n_in != want) begin
                fails++;
                $display("FAIL %s spacing M=%0d: actual %0d inputs, expected %0d",
                         first_flag ? "R5" : "R2/R3", cur_m, n_in, want);
            end
            first_flag = 1'b0;
            if (vcount > 5) begin
                tests++;
                if ($signed(pcm_out) != exp_val) begin
                    fails++;
                    $display("FAIL %s value M=%0d: actual %0d, expected %0d",
                             vtag, cur_m, $signed(pcm_out), exp_val);
                end
            end
            n_in = 0;
        end
        mod_bit = b;
        mod_en  = e;
        if (e) n_in++;
    endtask

    initial begin
        logic [15:0] held;
        rst_n    = 1'b0;
        mod_en   = 1'b0;
        mod_bit  = 1'b0;
        rate_sel = 2'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (pcm_out != 16'd0 || pcm_valid != 1'b0) begin
            fails++;
            $display("FAIL R8 reset: actual out=%0d valid=%0b, expected 0 0", pcm_out, pcm_valid);
        end

        for (int s = 0; s < 4; s++) begin
            io(1'b0, 1'b0);
            rate_sel = 2'(s);
            io(1'b0, 1'b0);
            n_in = 0;
            first_flag = 1'b1;
            cur_m = 32 << s;
            for (int p = 0; p < 7; p++) begin
                int idx;
                int g;
                int ones;
                ones = $countones(mask_a[p] & 8'((1 << per_a[p]) - 1));
                exp_val = ((2 * ones - per_a[p]) * 32768) / per_a[p];
                if (exp_val > 32767) exp_val = 32767;
                if (p < 2) vtag = (s == 3) ? "R1/R9" : "R1";
                else if (p == 2) vtag = "R7";
                else vtag = (p % 2 == 1) ? "R6/R4" : "R6";
                vcount = 0;
                idx = 0;
                g = 0;
                while (vcount < 9) begin
                    logic e;
                    logic b;
                    e = (p % 2 == 1) ? (g % 3 != 2) : 1'b1;
                    g++;
                    b = mask_a[p][idx % per_a[p]];
                    if (!e) b = ~b;
                    io(b, e);
                    if (e) idx++;
                end
            end
        end

        // R4 idle: no strobe while the enable stays low, output held (R8)
        @(negedge clk);
        held = pcm_out;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 700; k++) begin
                mod_en  = 1'b0;
                mod_bit = k[0];
                @(negedge clk);
                if (pcm_valid) seen++;
            end
            tests++;
            if (seen != 0 || pcm_out != held) begin
                fails++;
                $display("FAIL R4 idle: actual %0d strobes out=%0d, expected 0 strobes out=%0d",
                         seen, pcm_out, held);
            end
        end

        report();
        $finish;
    end
endmodule